// File: doc/BRIEF.md
# Tiled Read-Compute-Write Pipeline Sequencer

This block runs one composite command as a tiled pipeline. A command gives a total transfer length, a tile size and a single compute opcode. The block cuts the work into tiles. Each tile passes through three stages in order: a DMA read into a staging buffer, a compute on that buffer, and a DMA write out of a second staging buffer. Each stage start is a one-cycle pulse to its engine. The stage is held busy until the engine returns a one-cycle completion.

Different tiles overlap in time. The limits are one outstanding read, one outstanding write and one outstanding compute. Matrix and element-wise work share the single compute slot. Staging buffers come from a fixed reserved region: two input slots and two output slots, used in ping-pong. A tile keeps its slots until its write completes. The block pulses an event when a tile's input has landed, and pulses a completion once the last write is accepted.

Top module: `tile_pipe_seq`

## Requirements
- R1: A command is accepted only while `cmd_ready_o` is 1. It is rejected when any of the following holds: the opcode is not exactly one of 2'b01 (matrix) or 2'b10 (element-wise), the length is zero, or the tile size is zero. A rejected command pulses `cmd_err_o` in the next cycle, starts no stage and leaves `cmd_ready_o` at 1.
- R2: A command of length L and tile size T runs ceil(L/T) tiles. Every tile carries T words except the last, which carries the remainder. In each stage, tile IDs start at 0 and increase by one per start.
- R3: The compute of tile t starts only after the read completion of tile t is accepted. The write of tile t starts only after the compute completion of tile t is accepted.
- R4: At most one read, one compute and one write are outstanding at any time.
- R5: Each stage starts in the first cycle in which its own rules (R3, R4, R6) allow it. This lets a read of a later tile, a compute and a write of an earlier tile run together.
- R6: Tile t reads into input slot RSV_BASE + (t mod 2)*BUF_SZ (0x400/0x500 by default). It writes from output slot RSV_BASE + (2 + t mod 2)*BUF_SZ (0x600/0x700). Input and output slots never coincide. The read of tile t waits until the write of tile t-2 has completed.
- R7: `tile_ready_o` pulses in the cycle after a read completion is accepted, with `tile_ready_id_o` set to that tile's ID.
- R8: `done_o` pulses exactly once per command, in the cycle after the final write completion is accepted. `cmd_ready_o` is 1 in that same cycle.
- R9: `cp_op_o` carries the accepted command's opcode on every compute start.
- R10: A completion input that arrives while its stage has nothing outstanding is ignored. It produces no tile-ready pulse and no done pulse, and it does not disturb the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Sequencer idle, command can be taken |
| cmd_len_i | input | LEN_W | Total transfer length in words |
| cmd_tile_i | input | LEN_W | Tile size in words |
| cmd_op_i | input | 2 | Compute opcode (01 matrix, 10 element-wise) |
| cmd_err_o | output | 1 | Command rejected pulse |
| rd_start_o | output | 1 | Read start pulse |
| rd_id_o | output | LEN_W | Tile ID of the read |
| rd_len_o | output | LEN_W | Words to read |
| rd_addr_o | output | ADDR_W | Input staging slot address |
| rd_done_i | input | 1 | Read completion pulse |
| cp_start_o | output | 1 | Compute start pulse |
| cp_op_o | output | 2 | Compute opcode |
| cp_id_o | output | LEN_W | Tile ID of the compute |
| cp_len_o | output | LEN_W | Words to compute |
| cp_src_o | output | ADDR_W | Input staging slot address |
| cp_dst_o | output | ADDR_W | Output staging slot address |
| cp_done_i | input | 1 | Compute completion pulse |
| wr_start_o | output | 1 | Write start pulse |
| wr_id_o | output | LEN_W | Tile ID of the write |
| wr_len_o | output | LEN_W | Words to write |
| wr_addr_o | output | ADDR_W | Output staging slot address |
| wr_done_i | input | 1 | Write completion pulse |
| tile_ready_o | output | 1 | Tile input landed pulse |
| tile_ready_id_o | output | LEN_W | ID of the tile that became ready |
| done_o | output | 1 | Command complete pulse |

## Verification
The case hardest to reach from the ports is a read held back only by buffer ownership. This happens when both input slots belong to tiles whose writes are still running, while the read channel itself is idle. The bench gets there by making the write engine model much slower than the read and compute models, across commands of up to nine tiles. Two tiles then pile up waiting for the writer. It also covers the reverse shape, where a slow compute forces a read of the next tile to run alongside it. In every cycle the bench predicts from its own tile accounting whether each stage must start, so a late start is caught as well as an early one.

// File: rtl/tps_pkg.sv
package tps_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_MAT  = 2'b01,
    OP_ELT  = 2'b10,
    OP_MIX  = 2'b11
  } tps_op_e;

  function automatic logic op_ok(logic [1:0] op);
    return (op == OP_MAT) || (op == OP_ELT);
  endfunction
endpackage

// File: rtl/tps_credit.sv
// Up/down occupancy counter bounded by MAX.
module tps_credit #(
  parameter int MAX = 2,
  localparam int CW = $clog2(MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic [CW-1:0] cnt_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (inc_i && !dec_i) cnt_q <= cnt_q + 1'b1;
    else if (dec_i && !inc_i) cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o   = cnt_q;
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(MAX));

  // R3: a consumer never takes an item that was not produced
  assert_no_underflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> (!empty_o || inc_i));
  // R6: slot/queue occupancy never exceeds its bound
  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !dec_i) |-> !full_o);
endmodule

// File: rtl/tps_stage.sv
// One pipeline stage: walks the remaining length in tile steps, one outstanding op.
module tps_stage #(
  parameter int LEN_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [LEN_W-1:0] tile_i,
  input  logic             grant_i,
  input  logic             done_i,
  output logic             start_o,
  output logic [LEN_W-1:0] id_o,
  output logic [LEN_W-1:0] len_o,
  output logic [LEN_W-1:0] last_id_o,
  output logic             acc_o,
  output logic             drained_o
);
  logic [LEN_W-1:0] rem_q, tile_q, id_q;
  logic             busy_q;

  assign len_o     = (rem_q < tile_q) ? rem_q : tile_q;
  assign drained_o = (rem_q == '0);
  assign start_o   = !drained_o && !busy_q && grant_i;
  assign acc_o     = done_i && busy_q;
  assign id_o      = id_q;
  assign last_id_o = id_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      tile_q <= '0;
      id_q   <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      rem_q  <= len_i;
      tile_q <= tile_i;
      id_q   <= '0;
      busy_q <= 1'b0;
    end else if (start_o) begin
      rem_q  <= rem_q - len_o;
      id_q   <= id_q + 1'b1;
      busy_q <= 1'b1;
    end else if (acc_o) begin
      busy_q <= 1'b0;
    end
  end

  assert_single_outstanding_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  assert_tile_nonempty_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (len_o != '0));
endmodule

// File: rtl/tile_pipe_seq.sv
module tile_pipe_seq
  import tps_pkg::*;
#(
  parameter int LEN_W    = 12,
  parameter int ADDR_W   = 16,
  parameter int RSV_BASE = 'h400,
  parameter int BUF_SZ   = 'h100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [LEN_W-1:0]  cmd_len_i,
  input  logic [LEN_W-1:0]  cmd_tile_i,
  input  logic [1:0]        cmd_op_i,
  output logic              cmd_err_o,
  output logic              rd_start_o,
  output logic [LEN_W-1:0]  rd_id_o,
  output logic [LEN_W-1:0]  rd_len_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_done_i,
  output logic              cp_start_o,
  output logic [1:0]        cp_op_o,
  output logic [LEN_W-1:0]  cp_id_o,
  output logic [LEN_W-1:0]  cp_len_o,
  output logic [ADDR_W-1:0] cp_src_o,
  output logic [ADDR_W-1:0] cp_dst_o,
  input  logic              cp_done_i,
  output logic              wr_start_o,
  output logic [LEN_W-1:0]  wr_id_o,
  output logic [LEN_W-1:0]  wr_len_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  input  logic              wr_done_i,
  output logic              tile_ready_o,
  output logic [LEN_W-1:0]  tile_ready_id_o,
  output logic              done_o
);
  localparam int NBUF = 2;
  localparam logic [ADDR_W-1:0] IN0  = ADDR_W'(RSV_BASE);
  localparam logic [ADDR_W-1:0] IN1  = ADDR_W'(RSV_BASE + BUF_SZ);
  localparam logic [ADDR_W-1:0] OUT0 = ADDR_W'(RSV_BASE + NBUF * BUF_SZ);
  localparam logic [ADDR_W-1:0] OUT1 = ADDR_W'(RSV_BASE + (NBUF + 1) * BUF_SZ);
  localparam int CW = $clog2(NBUF + 1);

  logic active_q, done_q, err_q, tr_q;
  logic [LEN_W-1:0] tr_id_q;
  logic [1:0] op_q;
  logic load, cmd_take, last_wr;

  logic rd_acc, cp_acc, wr_acc;
  logic rd_drn, cp_drn, wr_drn;
  logic [LEN_W-1:0] rd_last, cp_last, wr_last;
  logic live_full, rdq_empty, cpq_empty;
  logic live_empty, rdq_full, cpq_full;
  logic [CW-1:0] live_cnt, rdq_cnt, cpq_cnt;

  assign cmd_ready_o = !active_q;
  assign cmd_take    = cmd_valid_i && !active_q;
  assign load        = cmd_take && op_ok(cmd_op_i) && (cmd_len_i != '0) && (cmd_tile_i != '0);
  assign last_wr     = wr_acc && wr_drn;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      tr_q     <= 1'b0;
      tr_id_q  <= '0;
      op_q     <= OP_NONE;
    end else begin
      done_q <= last_wr;
      err_q  <= cmd_take && !load;
      tr_q   <= rd_acc;
      if (rd_acc) tr_id_q <= rd_last;
      if (load) begin
        active_q <= 1'b1;
        op_q     <= cmd_op_i;
      end else if (last_wr) begin
        active_q <= 1'b0;
      end
    end
  end

  tps_stage #(.LEN_W(LEN_W)) u_rd (
    .clk_i, .rst_ni, .load_i(load), .len_i(cmd_len_i), .tile_i(cmd_tile_i),
    .grant_i(active_q && !live_full), .done_i(rd_done_i),
    .start_o(rd_start_o), .id_o(rd_id_o), .len_o(rd_len_o), .last_id_o(rd_last),
    .acc_o(rd_acc), .drained_o(rd_drn)
  );
  tps_stage #(.LEN_W(LEN_W)) u_cp (
    .clk_i, .rst_ni, .load_i(load), .len_i(cmd_len_i), .tile_i(cmd_tile_i),
    .grant_i(!rdq_empty), .done_i(cp_done_i),
    .start_o(cp_start_o), .id_o(cp_id_o), .len_o(cp_len_o), .last_id_o(cp_last),
    .acc_o(cp_acc), .drained_o(cp_drn)
  );
  tps_stage #(.LEN_W(LEN_W)) u_wr (
    .clk_i, .rst_ni, .load_i(load), .len_i(cmd_len_i), .tile_i(cmd_tile_i),
    .grant_i(!cpq_empty), .done_i(wr_done_i),
    .start_o(wr_start_o), .id_o(wr_id_o), .len_o(wr_len_o), .last_id_o(wr_last),
    .acc_o(wr_acc), .drained_o(wr_drn)
  );

  // tiles holding staging slots: from read start to write completion
  tps_credit #(.MAX(NBUF)) u_live (
    .clk_i, .rst_ni, .inc_i(rd_start_o), .dec_i(wr_acc),
    .cnt_o(live_cnt), .empty_o(live_empty), .full_o(live_full)
  );
  // tiles read, not yet computed
  tps_credit #(.MAX(NBUF)) u_rdq (
    .clk_i, .rst_ni, .inc_i(rd_acc), .dec_i(cp_start_o),
    .cnt_o(rdq_cnt), .empty_o(rdq_empty), .full_o(rdq_full)
  );
  // tiles computed, not yet written
  tps_credit #(.MAX(NBUF)) u_cpq (
    .clk_i, .rst_ni, .inc_i(cp_acc), .dec_i(wr_start_o),
    .cnt_o(cpq_cnt), .empty_o(cpq_empty), .full_o(cpq_full)
  );

  assign rd_addr_o       = rd_id_o[0] ? IN1 : IN0;
  assign cp_src_o        = cp_id_o[0] ? IN1 : IN0;
  assign cp_dst_o        = cp_id_o[0] ? OUT1 : OUT0;
  assign wr_addr_o       = wr_id_o[0] ? OUT1 : OUT0;
  assign cp_op_o         = op_q;
  assign cmd_err_o       = err_q;
  assign done_o          = done_q;
  assign tile_ready_o    = tr_q;
  assign tile_ready_id_o = tr_id_q;

  assert_err_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_err_o |-> (cmd_ready_o && !rd_start_o));
  assert_cp_after_rd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cp_start_o |-> (cp_id_o <= rd_last));
  assert_wr_after_cp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_start_o |-> (wr_id_o <= cp_last));
  assert_buf_split_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cp_start_o |-> (cp_src_o != cp_dst_o));
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_ready_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cmd_ready_o && live_empty && rdq_cnt == '0 && cpq_cnt == '0));
  assert_wr_id_trail_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_acc |-> (wr_last < rd_id_o));
endmodule

// File: tb/tile_pipe_seq_tb.sv
module tile_pipe_seq_tb_top;
  localparam int LW = 12;
  localparam int AW = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk_i = ~clk_i;

  logic cmd_valid_i = 1'b0, cmd_ready_o, cmd_err_o;
  logic [LW-1:0] cmd_len_i = '0, cmd_tile_i = '0;
  logic [1:0] cmd_op_i = '0;
  logic rd_start_o, cp_start_o, wr_start_o;
  logic rd_done_i = 1'b0, cp_done_i = 1'b0, wr_done_i = 1'b0;
  logic [LW-1:0] rd_id_o, rd_len_o, cp_id_o, cp_len_o, wr_id_o, wr_len_o, tile_ready_id_o;
  logic [AW-1:0] rd_addr_o, cp_src_o, cp_dst_o, wr_addr_o;
  logic [1:0] cp_op_o;
  logic tile_ready_o, done_o;

  tile_pipe_seq dut_i (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_ready_o, .cmd_len_i, .cmd_tile_i, .cmd_op_i, .cmd_err_o,
    .rd_start_o, .rd_id_o, .rd_len_o, .rd_addr_o, .rd_done_i,
    .cp_start_o, .cp_op_o, .cp_id_o, .cp_len_o, .cp_src_o, .cp_dst_o, .cp_done_i,
    .wr_start_o, .wr_id_o, .wr_len_o, .wr_addr_o, .wr_done_i,
    .tile_ready_o, .tile_ready_id_o, .done_o
  );

  int total = 0, bad = 0, cyc = 0;
  bit hung = 0;

  // bench model of the command in flight
  bit act, rd_p, cp_p, wr_p, exp_err;
  int rd_id, cp_id, wr_id, rd_rem, cp_rem, wr_rem, rdq, cpq, live;
  int rd_t, cp_t, wr_t, lr, lc, lw, tsz, opc;
  int seen_rd_cp_overlap = 0, seen_stall = 0;

  task automatic chk(bit ok, string req, longint a, longint e);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, a, e);
    end
  endtask

  function automatic int tl(int rem, int t);
    return (rem < t) ? rem : t;
  endfunction
  function automatic int in_a(int id);
    return 'h400 + (id % 2) * 'h100;
  endfunction
  function automatic int out_a(int id);
    return 'h600 + (id % 2) * 'h100;
  endfunction

  task automatic step();
    bit exp_tr, exp_dn, es;
    int tr_id;
    @(negedge clk_i);
    cyc++;
    if (cyc > 150000) hung = 1;
    exp_tr = 0; exp_dn = 0; tr_id = 0;
    // command taken at the edge just passed
    if (cmd_valid_i) begin
      chk(cmd_err_o == exp_err, "R1 err pulse", cmd_err_o, exp_err);
      if (!exp_err) begin
        act = 1; rd_p = 0; cp_p = 0; wr_p = 0;
        rd_id = 0; cp_id = 0; wr_id = 0; rdq = 0; cpq = 0; live = 0;
        rd_rem = int'(cmd_len_i); cp_rem = rd_rem; wr_rem = rd_rem;
      end
      cmd_valid_i = 0;
    end else begin
      chk(cmd_err_o == 1'b0, "R1 no err", cmd_err_o, 0);
    end
    // completions accepted at the edge just passed (R10: only when outstanding)
    if (rd_done_i && rd_p) begin rd_p = 0; rdq++; exp_tr = 1; tr_id = rd_id - 1; end
    if (cp_done_i && cp_p) begin cp_p = 0; cpq++; end
    if (wr_done_i && wr_p) begin
      wr_p = 0; live--;
      if (wr_rem == 0) begin exp_dn = 1; act = 0; end
    end
    chk(tile_ready_o == exp_tr, "R7 tile_ready", tile_ready_o, exp_tr);
    if (exp_tr) chk(int'(tile_ready_id_o) == tr_id, "R7 tile_ready id", tile_ready_id_o, tr_id);
    chk(done_o == exp_dn, "R8 done pulse", done_o, exp_dn);
    if (exp_dn) chk(cmd_ready_o == 1'b1, "R8 ready with done", cmd_ready_o, 1);
    rd_done_i = 0; cp_done_i = 0; wr_done_i = 0;
    // engine models
    if (rd_p && rd_t > 0) begin rd_t--; if (rd_t == 0) rd_done_i = 1; end
    if (cp_p && cp_t > 0) begin cp_t--; if (cp_t == 0) cp_done_i = 1; end
    if (wr_p && wr_t > 0) begin wr_t--; if (wr_t == 0) wr_done_i = 1; end
    // read stage
    es = act && !rd_p && rd_rem > 0 && live < 2;
    if (act && !rd_p && rd_rem > 0 && live >= 2) seen_stall++;
    chk(rd_start_o == es, "R5/R6 read start timing", rd_start_o, es);
    if (rd_start_o && es) begin
      chk(int'(rd_id_o) == rd_id, "R2 read id", rd_id_o, rd_id);
      chk(int'(rd_len_o) == tl(rd_rem, tsz), "R2 read len", rd_len_o, tl(rd_rem, tsz));
      chk(int'(rd_addr_o) == in_a(rd_id), "R6 read slot", rd_addr_o, in_a(rd_id));
      if (cp_p) seen_rd_cp_overlap++;
      rd_rem -= tl(rd_rem, tsz); rd_id++; rd_p = 1; live++; rd_t = lr;
    end
    // compute stage
    es = act && !cp_p && cp_rem > 0 && rdq > 0;
    chk(cp_start_o == es, "R3/R4/R5 compute start timing", cp_start_o, es);
    if (cp_start_o && es) begin
      chk(int'(cp_id_o) == cp_id, "R2 compute id", cp_id_o, cp_id);
      chk(int'(cp_len_o) == tl(cp_rem, tsz), "R2 compute len", cp_len_o, tl(cp_rem, tsz));
      chk(int'(cp_src_o) == in_a(cp_id), "R6 compute src", cp_src_o, in_a(cp_id));
      chk(int'(cp_dst_o) == out_a(cp_id), "R6 compute dst", cp_dst_o, out_a(cp_id));
      chk(int'(cp_op_o) == opc, "R9 opcode", cp_op_o, opc);
      cp_rem -= tl(cp_rem, tsz); cp_id++; cp_p = 1; rdq--; cp_t = lc;
    end
    // write stage
    es = act && !wr_p && wr_rem > 0 && cpq > 0;
    chk(wr_start_o == es, "R3/R4/R5 write start timing", wr_start_o, es);
    if (wr_start_o && es) begin
      chk(int'(wr_id_o) == wr_id, "R2 write id", wr_id_o, wr_id);
      chk(int'(wr_len_o) == tl(wr_rem, tsz), "R2 write len", wr_len_o, tl(wr_rem, tsz));
      chk(int'(wr_addr_o) == out_a(wr_id), "R6 write slot", wr_addr_o, out_a(wr_id));
      wr_rem -= tl(wr_rem, tsz); wr_id++; wr_p = 1; cpq--; wr_t = lw;
    end
  endtask

  task automatic run_cmd(int len, int tile, int op, int a, int b, int c);
    int tiles, n;
    if (hung) return;
    chk(cmd_ready_o == 1'b1, "R8 ready before command", cmd_ready_o, 1);
    lr = a; lc = b; lw = c; tsz = tile; opc = op;
    exp_err = !(op == 1 || op == 2) || len == 0 || tile == 0;
    cmd_len_i = LW'(len); cmd_tile_i = LW'(tile); cmd_op_i = 2'(op);
    cmd_valid_i = 1;
    step();
    n = 0;
    while (act && !hung) begin step(); if (rd_start_o) n++; end
    if (!exp_err) begin
      tiles = (len + tile - 1) / tile;
      chk(rd_id == tiles && wr_id == tiles, "R2 tile count", wr_id, tiles);
    end
    step();
    chk(cmd_ready_o == 1'b1, "R8 idle after command", cmd_ready_o, 1);
  endtask

  initial begin
    chk(cmd_ready_o == 1'b1 && done_o == 1'b0 && rd_start_o == 1'b0, "R8 reset state",
        {cmd_ready_o, done_o, rd_start_o}, 3'b100);
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    step();
    // R1: rejected commands
    run_cmd(5, 2, 0, 1, 1, 1);
    run_cmd(5, 2, 3, 1, 1, 1);
    run_cmd(0, 2, 1, 1, 1, 1);
    run_cmd(5, 0, 2, 1, 1, 1);
    // R10: stray completions while idle
    rd_done_i = 1; cp_done_i = 1; wr_done_i = 1;
    step();
    step();
    chk(tile_ready_o == 1'b0 && done_o == 1'b0, "R10 stray completions ignored",
        {tile_ready_o, done_o}, 0);
    // sweep
    for (int lat = 0; lat < 4; lat++) begin
      for (int op = 1; op <= 2; op++) begin
        for (int tile = 1; tile <= 4; tile++) begin
          for (int len = 1; len <= 9; len++) begin
            case (lat)
              0: run_cmd(len, tile, op, 1, 1, 1);
              1: run_cmd(len, tile, op, 1, 4, 1);
              2: run_cmd(len, tile, op, 1, 1, 6);
              default: run_cmd(len, tile, op, 3, 2, 2);
            endcase
          end
        end
      end
    end
    chk(seen_rd_cp_overlap > 0, "R5 read overlapped compute", seen_rd_cp_overlap, 1);
    chk(seen_stall > 0, "R6 read held by slot ownership", seen_stall, 1);
    if (hung) chk(1'b0, "watchdog", cyc, 150000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule